// File: doc/BRIEF.md
# Servo Iteration Sequencer

This block paces the repeating iteration of a multi-channel servo loop. Each iteration runs three stage engines in a fixed order: input sampling, filter compute and output synthesizer update. Each engine is driven through a one-clock start strobe and answers with a one-clock done strobe. A single control bit starts and stops the iterations. Every iteration begins with the sampling stage, so setting the bit lines servo updates up with the moment of that register write. Clearing the bit never aborts work in flight. The iteration already under way runs to its final output update, and the sequencer then parks.

A cycle-complete output has two behaviours. While the servo runs, it pulses for one clock at the end of each iteration. Once the block is stopped and drained, it stays high. The block also gathers per-channel clip events from the filter engine into sticky flags. Only channels enabled in an activity mask are gathered. All flags are returned and cleared by a single status read.

Software reaches the block through a small register port:

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | run bit at bit 0 |
| 1 | read/write | per-channel activity mask |
| 2 | read only | status word |

Top module: `servo_seq`

## Requirements
- R1: After reset the run bit and the activity mask are 0, all clip flags are 0, no start strobe is high, and the cycle-complete output is 1.
- R2: Writing 1 to bit 0 of address 0 raises the sampling start strobe for one clock, beginning exactly one clock after the write takes effect. A sampling start only ever follows a clock in which the run bit was 1.
- R3: Stages run in the order sampling, filter, update. The filter start rises exactly one clock after the sampling done, and the update start rises exactly one clock after the filter done. At most one start strobe is high in any clock.
- R4: While running, the cycle-complete output is high for exactly one clock after each update done, in the same clock as the next sampling start.
- R5: When the run bit is cleared mid-iteration, that iteration completes through its update stage. No further sampling start follows, and the cycle-complete output rises only in the clock after an update done.
- R6: While the block is stopped and drained, the cycle-complete output stays at 1.
- R7: If the run bit is cleared and set again before the current iteration finishes, that iteration completes first, and a fresh iteration then starts at the sampling stage.
- R8: The status word at address 2 holds the run bit at bit 0, cycle-complete at bit 1 and clip flag n at bit 8+n; all other bits are 0. Read data appears on the clock after the read strobe and holds until the next read.
- R9: A clip event on channel n whose mask bit n (address 1, bit n) is 1 sets clip flag n, which then stays set until a status read.
- R10: A status read returns the flags and clears them all in the same access. A clip event in the same clock as the read stays set and is returned by the next read.
- R11: Clip events on channels whose mask bit is 0 leave the flags unchanged. The mask reads back as written.
- R12: A stage done strobe that arrives while its stage is not active is ignored. It starts no stage and ends no iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous active-low reset |
| regWrEn | input | 1 | register write strobe |
| regRdEn | input | 1 | register read strobe |
| regAddr | input | 2 | register address |
| regWrData | input | NCH | write data |
| regRdData | output | 8+NCH | registered read data |
| clipIn | input | NCH | per-channel clip events from filter engine |
| adcStart | output | 1 | sampling stage start strobe |
| adcDone | input | 1 | sampling stage done strobe |
| iirStart | output | 1 | filter stage start strobe |
| iirDone | input | 1 | filter stage done strobe |
| ddsStart | output | 1 | update stage start strobe |
| ddsDone | input | 1 | update stage done strobe |
| cycleDone | output | 1 | iteration-complete pulse or drained level |

## Verification
The bench builds the block with its default NCH of 8. With that value the clip flags fill bits 8 to 15 of the status word, and a status comparison covers every flag position, including channels masked off. The stub stage engines answer with per-scenario latencies, from two clocks up to eight. This makes it possible to land a stop request or a restart inside a chosen stage, and to inject stray done strobes while another stage is still busy.

// File: rtl/servo_seq_pkg.sv
package servo_seq_pkg;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  // first status bit that carries a clip flag
  localparam int CLIP_LSB = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_COMPUTE,
    ST_UPDATE
  } seqStage_e;

  // strobes from the sequencer control to the register datapath
  typedef struct packed {
    logic done;
  } seqStrobe_t;

endpackage

// File: rtl/servo_seq_ctrl.sv
module servo_seq_ctrl
  import servo_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enableBit,
  input  logic       adcDone,
  input  logic       iirDone,
  input  logic       ddsDone,
  output logic       adcStart,
  output logic       iirStart,
  output logic       ddsStart,
  output seqStrobe_t strobe
);

  seqStage_e stage;
  logic      endPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage    <= ST_IDLE;
      adcStart <= 1'b0;
      iirStart <= 1'b0;
      ddsStart <= 1'b0;
      endPulse <= 1'b0;
    end else begin
      adcStart <= 1'b0;
      iirStart <= 1'b0;
      ddsStart <= 1'b0;
      endPulse <= 1'b0;
      case (stage)
        ST_IDLE: begin
          if (enableBit) begin
            stage    <= ST_SAMPLE;
            adcStart <= 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (adcDone) begin
            stage    <= ST_COMPUTE;
            iirStart <= 1'b1;
          end
        end
        ST_COMPUTE: begin
          if (iirDone) begin
            stage    <= ST_UPDATE;
            ddsStart <= 1'b1;
          end
        end
        ST_UPDATE: begin
          if (ddsDone) begin
            endPulse <= 1'b1;
            if (enableBit) begin
              stage    <= ST_SAMPLE;
              adcStart <= 1'b1;
            end else begin
              stage <= ST_IDLE;
            end
          end
        end
        default: stage <= ST_IDLE;
      endcase
    end
  end

  // one-clock pulse at each iteration end, steady level while parked
  always_comb begin
    strobe.done = endPulse | (stage == ST_IDLE);
  end

endmodule

// File: rtl/servo_seq_clip.sv
module servo_seq_clip (
  input  logic clk,
  input  logic rstN,
  input  logic clipEvent,
  input  logic chanActive,
  input  logic clearAll,
  output logic flag
);

  // a new event wins over the clear of the same clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flag <= 1'b0;
    else       flag <= (flag & ~clearAll) | (clipEvent & chanActive);
  end

endmodule

// File: rtl/servo_seq_regs.sv
module servo_seq_regs
  import servo_seq_pkg::*;
#(
  parameter  int NCH    = 8,
  localparam int STAT_W = CLIP_LSB + NCH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NCH-1:0]    regWrData,
  output logic [STAT_W-1:0] regRdData,
  input  logic [NCH-1:0]    clipIn,
  input  seqStrobe_t        strobe,
  output logic              enableBit
);

  logic [NCH-1:0]    activeMask;
  logic [NCH-1:0]    clipFlags;
  logic [STAT_W-1:0] statusWord;
  logic [STAT_W-1:0] readMux;
  logic              statRead;

  assign statRead = regRdEn && (regAddr == ADDR_STAT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableBit  <= 1'b0;
      activeMask <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_CTRL) enableBit  <= regWrData[0];
      if (regAddr == ADDR_MASK) activeMask <= regWrData;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    servo_seq_clip u_clip (
      .clk       (clk),
      .rstN      (rstN),
      .clipEvent (clipIn[ch]),
      .chanActive(activeMask[ch]),
      .clearAll  (statRead),
      .flag      (clipFlags[ch])
    );
  end

  always_comb begin
    statusWord                = '0;
    statusWord[0]             = enableBit;
    statusWord[1]             = strobe.done;
    statusWord[CLIP_LSB +: NCH] = clipFlags;
  end

  always_comb begin
    readMux = '0;
    case (regAddr)
      ADDR_CTRL: readMux[0]       = enableBit;
      ADDR_MASK: readMux[NCH-1:0] = activeMask;
      ADDR_STAT: readMux          = statusWord;
      default:   readMux          = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= readMux;
  end

endmodule

// File: rtl/servo_seq.sv
module servo_seq
  import servo_seq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic                    regRdEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [NCH-1:0]          regWrData,
  output logic [CLIP_LSB+NCH-1:0] regRdData,
  input  logic [NCH-1:0]          clipIn,
  output logic                    adcStart,
  input  logic                    adcDone,
  output logic                    iirStart,
  input  logic                    iirDone,
  output logic                    ddsStart,
  input  logic                    ddsDone,
  output logic                    cycleDone
);

  seqStrobe_t strobe;
  logic       enableBit;

  servo_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enableBit(enableBit),
    .adcDone  (adcDone),
    .iirDone  (iirDone),
    .ddsDone  (ddsDone),
    .adcStart (adcStart),
    .iirStart (iirStart),
    .ddsStart (ddsStart),
    .strobe   (strobe)
  );

  servo_seq_regs #(.NCH(NCH)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .clipIn   (clipIn),
    .strobe   (strobe),
    .enableBit(enableBit)
  );

  assign cycleDone = strobe.done;

endmodule

// File: rtl/servo_seq_chk.sv
module servo_seq_chk (
  input logic clk,
  input logic rstN,
  input logic enableBit,
  input logic adcStart,
  input logic iirStart,
  input logic ddsStart,
  input logic adcDone,
  input logic iirDone,
  input logic ddsDone,
  input logic cycleDone
);

  // R2
  sample_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> $past(enableBit));

  // R3
  filter_after_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    iirStart |-> $past(adcDone));

  // R3
  update_after_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    ddsStart |-> $past(iirDone));

  // R3
  single_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({adcStart, iirStart, ddsStart}));

  // R4
  done_pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && adcStart) |=> !cycleDone);

  // R5
  done_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cycleDone) |-> $past(ddsDone));

endmodule

bind servo_seq servo_seq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enableBit(enableBit),
  .adcStart (adcStart),
  .iirStart (iirStart),
  .ddsStart (ddsStart),
  .adcDone  (adcDone),
  .iirDone  (iirDone),
  .ddsDone  (ddsDone),
  .cycleDone(cycleDone)
);

// File: tb/test_servo_seq.sv
module test_servo_seq;

  localparam int NCH = 8;

  logic            clk = 1'b0;
  logic            rstN;
  logic            regWrEn;
  logic            regRdEn;
  logic [1:0]      regAddr;
  logic [NCH-1:0]  regWrData;
  logic [15:0]     regRdData;
  logic [NCH-1:0]  clipIn;
  logic            adcStart, iirStart, ddsStart;
  logic            adcDone, iirDone, ddsDone;
  logic            cycleDone;

  int nChecks = 0;
  int nFail   = 0;
  int adcLat  = 2;
  int iirLat  = 2;
  int ddsLat  = 2;
  int expQ[$];

  always #4 clk = ~clk;

  servo_seq #(.NCH(NCH)) i_servo_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .clipIn(clipIn), .adcStart(adcStart), .adcDone(adcDone),
    .iirStart(iirStart), .iirDone(iirDone), .ddsStart(ddsStart),
    .ddsDone(ddsDone), .cycleDone(cycleDone)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected stage start codes 1,2,3
  task automatic pushCycles(input int n);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(1);
      expQ.push_back(2);
      expQ.push_back(3);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input int d);
    regWrEn   = 1'b1;
    regAddr   = a;
    regWrData = NCH'(d);
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output int v);
    regRdEn = 1'b1;
    regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    v = int'(regRdData);
  endtask

  // stub stage engines
  initial begin
    adcDone = 1'b0;
    forever begin
      @(negedge clk);
      if (adcStart) begin
        repeat (adcLat - 1) @(negedge clk);
        adcDone = 1'b1;
        @(negedge clk);
        adcDone = 1'b0;
      end
    end
  end

  initial begin
    iirDone = 1'b0;
    forever begin
      @(negedge clk);
      if (iirStart) begin
        repeat (iirLat - 1) @(negedge clk);
        iirDone = 1'b1;
        @(negedge clk);
        iirDone = 1'b0;
      end
    end
  end

  initial begin
    ddsDone = 1'b0;
    forever begin
      @(negedge clk);
      if (ddsStart) begin
        repeat (ddsLat - 1) @(negedge clk);
        ddsDone = 1'b1;
        @(negedge clk);
        ddsDone = 1'b0;
      end
    end
  end

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && (adcStart || iirStart || ddsStart)) begin
        int got;
        got = adcStart ? 1 : (iirStart ? 2 : 3);
        if (expQ.size() == 0) check("R12", "unexpected stage start", got, 0);
        else                  check("R3", "stage start order", got, expQ.pop_front());
      end
    end
  end

  task automatic runTests();
    int v;
    rstN = 1'b0; regWrEn = 1'b0; regRdEn = 1'b0; regAddr = '0;
    regWrData = '0; clipIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "start strobes", int'({adcStart, iirStart, ddsStart}), 0);
    check("R1", "cycleDone", int'(cycleDone), 1);
    readReg(2'd2, v); check("R1", "status", v, 'h0002);
    readReg(2'd1, v); check("R1", "mask", v, 0);
    readReg(2'd0, v); check("R1", "run bit", v, 0);

    repeat (10) @(negedge clk);
    check("R6", "idle level", int'(cycleDone), 1);

    // R12 stray done strobes while parked
    adcDone = 1'b1; iirDone = 1'b1; ddsDone = 1'b1;
    @(negedge clk);
    adcDone = 1'b0; iirDone = 1'b0; ddsDone = 1'b0;
    repeat (3) @(negedge clk);
    check("R12", "idle after stray done", int'(cycleDone), 1);

    // R2 R4 R5 run three iterations, stop during the third
    adcLat = 3; iirLat = 2; ddsLat = 4;
    pushCycles(3);
    writeReg(2'd0, 1);
    check("R2", "no start yet", int'(adcStart), 0);
    @(negedge clk);
    check("R2", "sampling start", int'(adcStart), 1);
    for (int c = 0; c < 2; c++) begin
      @(posedge clk iff ddsDone);
      @(negedge clk);
      check("R4", "done pulse high", int'(cycleDone), 1);
      check("R4", "restart with pulse", int'(adcStart), 1);
      @(negedge clk);
      check("R4", "done pulse low", int'(cycleDone), 0);
    end
    writeReg(2'd0, 0);
    @(posedge clk iff ddsDone);
    @(negedge clk);
    check("R5", "drained done", int'(cycleDone), 1);
    check("R5", "no new sampling", int'(adcStart), 0);
    repeat (8) @(negedge clk);
    check("R6", "level after drain", int'(cycleDone), 1);
    readReg(2'd2, v); check("R8", "status parked", v, 'h0002);
    check("R5", "pending starts", expQ.size(), 0);

    // R7 stop and restart inside the filter stage
    adcLat = 2; iirLat = 6; ddsLat = 2;
    pushCycles(2);
    writeReg(2'd0, 1);
    @(posedge clk iff adcDone);
    @(negedge clk);
    check("R3", "filter start one clock after sampling done", int'(iirStart), 1);
    writeReg(2'd0, 0);
    writeReg(2'd0, 1);
    @(posedge clk iff ddsDone);
    @(negedge clk);
    check("R7", "done after drain", int'(cycleDone), 1);
    check("R7", "fresh sampling", int'(adcStart), 1);
    writeReg(2'd0, 0);
    @(posedge clk iff ddsDone);
    @(negedge clk);
    check("R7", "parked done", int'(cycleDone), 1);
    check("R7", "pending starts", expQ.size(), 0);

    // R12 stray done strobes during sampling, R8 status while running
    adcLat = 8; iirLat = 2; ddsLat = 2;
    pushCycles(1);
    writeReg(2'd0, 1);
    @(negedge clk);
    iirDone = 1'b1; ddsDone = 1'b1;
    @(negedge clk);
    iirDone = 1'b0; ddsDone = 1'b0;
    check("R12", "no filter start", int'(iirStart), 0);
    check("R12", "no iteration end", int'(cycleDone), 0);
    readReg(2'd2, v); check("R8", "status running", v, 'h0001);
    writeReg(2'd0, 0);
    @(posedge clk iff ddsDone);
    @(negedge clk);
    check("R12", "completes normally", int'(cycleDone), 1);
    check("R12", "pending starts", expQ.size(), 0);

    // R9 R10 R11 clip flags, channels 0..3 active
    writeReg(2'd1, 'h0F);
    readReg(2'd1, v); check("R11", "mask readback", v, 'h0F);
    clipIn = 8'h90;
    @(negedge clk);
    clipIn = '0;
    readReg(2'd2, v); check("R11", "inactive ignored", v, 'h0002);
    clipIn = 8'h03;
    @(negedge clk);
    clipIn = '0;
    repeat (5) @(negedge clk);
    readReg(2'd2, v); check("R9", "sticky flags", v, 'h0302);
    readReg(2'd2, v); check("R10", "cleared by read", v, 'h0002);
    clipIn = 8'h04; regRdEn = 1'b1; regAddr = 2'd2;
    @(negedge clk);
    clipIn = '0; regRdEn = 1'b0;
    check("R10", "read with coincident event", int'(regRdData), 'h0002);
    readReg(2'd2, v); check("R10", "coincident event kept", v, 'h0402);
    readReg(2'd2, v); check("R10", "cleared again", v, 'h0002);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (50000) @(posedge clk);
        check("WDG", "watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule